// File: doc/BRIEF.md
# Per-Bit Alias Address Translator

This block gives a simple synchronous bus master two views of one small register file. In the direct view, each address in the target region reaches one full data word, which can be read or written normally. In the alias view, a separate and larger address region holds one word for every bit of the target region. Reading an alias word returns that single bit. Writing an alias word sets or clears only that bit. Software can therefore change one bit without fetching, masking and storing the whole word.

An alias write becomes a read-modify-write of the target word, carried out inside the block. While that sequence runs, `ready` stays low and no other request is accepted. The update is therefore atomic with respect to anything else on the bus.

The alias word for target word `w`, bit `b` sits at `ALIAS_BASE + w*DATA_W + b`. The target words sit at `TGT_BASE + w`. Addresses count words. A request is presented on `req` together with `we`, `addr` and `wdata`. These are held until the master sees `ready` high at a rising edge.

Top module: `bitalias_xlate`

## Requirements
- R1: After synchronous reset (`rst` high), every target word reads as zero, `ready` is low and `rdata` is zero.
- R2: A direct write to `TGT_BASE + w` replaces the whole of word `w`, and a later direct read of that address returns the written value.
- R3: A direct read, an alias read and any access outside both regions each raise `ready` in the cycle after the request is accepted (accepted on edge N, completed on edge N+1).
- R4: An alias read returns the addressed target bit in `rdata[0]`, with `rdata[DATA_W-1:1]` zero.
- R5: Alias address `ALIAS_BASE + w*DATA_W + b` selects bit `b` of target word `w`, for every `w` below `WORDS` and every `b` below `DATA_W`.
- R6: An alias write with `wdata[0]` = 1 sets the selected bit. Every other bit of that word, and every other word, is left unchanged.
- R7: An alias write with `wdata[0]` = 0 clears the selected bit. Bits `wdata[DATA_W-1:1]` have no effect.
- R8: An alias write keeps `ready` low for two cycles after acceptance and completes on the third edge after it (accepted on edge N, completed on edge N+3). No other request is taken during that time.
- R9: A read from an address in neither region returns zero. A write to such an address changes no target word. Both still complete.
- R10: `ready` is high for exactly one cycle for each accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid; held until `ready` is seen |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data; only bit 0 is used for alias writes |
| rdata | output | DATA_W | Read data, valid while `ready` is high |
| ready | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the bit positions at the edges of the alias range: bit 0 of word 0 and bit 31 of the last word. A design that swapped the fields of the alias offset, or sliced it at the wrong place, would update the wrong word or the wrong bit there. Alias writes carry ones in the upper data bits while asking for a clear. Such a write would set the bit in a design that read the wrong data bit, and would smear ones across the word in a design that stored `wdata` directly. The latency of every access is counted, which catches a sequencer that skips or repeats its read phase. Out-of-range writes are followed by reads of real words, which exposes a decoder whose region compare is too wide. A long random mix of alias and direct accesses is compared against a bit-array model.

// File: rtl/bitalias_pkg.sv
package bitalias_pkg;

   // Region that an address falls into
   typedef enum logic [1:0] {
      REG_NONE  = 2'd0,
      REG_TGT   = 2'd1,
      REG_ALIAS = 2'd2
   } region_e;

   // Access sequencer states
   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_FETCH  = 2'd1,
      SQ_STORE  = 2'd2,
      SQ_DONE   = 2'd3
   } seq_state_e;

endpackage

// File: rtl/bitalias_decode.sv
module bitalias_decode
   import bitalias_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned WORDS      = 8,
   parameter int unsigned TGT_BASE   = 0,
   parameter int unsigned ALIAS_BASE = 1024,
   localparam int unsigned WIDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int unsigned BIT_W     = $clog2(DATA_W)
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [WIDX_W-1:0] word_idx,
   output logic [BIT_W-1:0]  bit_idx
);

   localparam logic [ADDR_W-1:0] TGT_B   = ADDR_W'(TGT_BASE);
   localparam logic [ADDR_W-1:0] ALIAS_B = ADDR_W'(ALIAS_BASE);
   localparam logic [ADDR_W-1:0] TGT_N   = ADDR_W'(WORDS);
   localparam logic [ADDR_W-1:0] ALIAS_N = ADDR_W'(WORDS * DATA_W);

   logic [ADDR_W-1:0] tgt_off;
   logic [ADDR_W-1:0] alias_off;
   logic              in_tgt;
   logic              in_alias;

   // Offsets wrap below the base, so one unsigned compare bounds each region
   assign tgt_off   = addr - TGT_B;
   assign alias_off = addr - ALIAS_B;
   assign in_tgt    = (tgt_off < TGT_N);
   assign in_alias  = (alias_off < ALIAS_N);

   always_comb begin
      region   = REG_NONE;
      word_idx = '0;
      bit_idx  = '0;
      if (in_tgt) begin
         region   = REG_TGT;
         word_idx = tgt_off[WIDX_W-1:0];
      end else if (in_alias) begin
         // alias offset = word * DATA_W + bit
         region   = REG_ALIAS;
         bit_idx  = alias_off[BIT_W-1:0];
         word_idx = alias_off[BIT_W +: WIDX_W];
      end
   end

endmodule

// File: rtl/bitalias_regfile.sv
module bitalias_regfile #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned WORDS     = 8,
   parameter logic [DATA_W-1:0] RESET_VAL = '0,
   localparam int unsigned WIDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WIDX_W-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [WIDX_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data
);

   logic [DATA_W-1:0] word_q [WORDS];

   for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst) begin
            word_q[gi] <= RESET_VAL;
         end else if (wr_en && (wr_idx == WIDX_W'(gi))) begin
            word_q[gi] <= wr_data;
         end
      end
   end

   assign rd_data = word_q[rd_idx];

   // A write reaches the addressed word on the following cycle
   assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (word_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/bitalias_ctrl.sv
module bitalias_ctrl
   import bitalias_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned WORDS   = 8,
   localparam int unsigned WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int unsigned BIT_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  region_e           region,
   input  logic [WIDX_W-1:0] word_in,
   input  logic [BIT_W-1:0]  bit_in,
   output logic [WIDX_W-1:0] rf_rd_idx,
   input  logic [DATA_W-1:0] rf_rd_data,
   output logic              rf_wr_en,
   output logic [WIDX_W-1:0] rf_wr_idx,
   output logic [DATA_W-1:0] rf_wr_data,
   output logic [DATA_W-1:0] rdata,
   output logic              ready
);

   seq_state_e        st_q, st_d;
   logic [WIDX_W-1:0] word_q;
   logic [BIT_W-1:0]  bit_q;
   logic              setv_q;
   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] rdata_q, rdata_d;
   logic              accept;
   logic              alias_rd_q;
   logic              none_rd_q;
   logic [DATA_W-1:0] merged;

   assign accept = (st_q == SQ_IDLE) && req;

   // Replace one bit of the fetched word with the requested value
   always_comb begin
      merged = hold_q;
      for (int i = 0; i < DATA_W; i++) begin
         if (bit_q == BIT_W'(i)) merged[i] = setv_q;
      end
   end

   always_comb begin
      st_d       = st_q;
      rdata_d    = rdata_q;
      rf_rd_idx  = (st_q == SQ_IDLE) ? word_in : word_q;
      rf_wr_en   = 1'b0;
      rf_wr_idx  = word_in;
      rf_wr_data = wdata;
      unique case (st_q)
         SQ_IDLE: begin
            if (req) begin
               rdata_d = '0;
               st_d    = SQ_DONE;
               unique case (region)
                  REG_TGT: begin
                     if (we) rf_wr_en = 1'b1;
                     else    rdata_d  = rf_rd_data;
                  end
                  REG_ALIAS: begin
                     if (we) st_d       = SQ_FETCH;
                     else    rdata_d[0] = rf_rd_data[bit_in];
                  end
                  default: ;
               endcase
            end
         end
         SQ_FETCH: st_d = SQ_STORE;
         SQ_STORE: begin
            rf_wr_en   = 1'b1;
            rf_wr_idx  = word_q;
            rf_wr_data = merged;
            st_d       = SQ_DONE;
         end
         SQ_DONE: st_d = SQ_IDLE;
         default: st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q       <= SQ_IDLE;
         word_q     <= '0;
         bit_q      <= '0;
         setv_q     <= 1'b0;
         hold_q     <= '0;
         rdata_q    <= '0;
         alias_rd_q <= 1'b0;
         none_rd_q  <= 1'b0;
      end else begin
         st_q    <= st_d;
         rdata_q <= rdata_d;
         if (accept) begin
            word_q     <= word_in;
            bit_q      <= bit_in;
            setv_q     <= wdata[0];
            alias_rd_q <= (region == REG_ALIAS) && !we;
            none_rd_q  <= (region == REG_NONE) && !we;
         end
         if (st_q == SQ_FETCH) hold_q <= rf_rd_data;
      end
   end

   assign ready = (st_q == SQ_DONE);
   assign rdata = rdata_q;

   assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (rst)
      ready |=> !ready);

   assert_alias_rd_bit0_R4: assert property (@(posedge clk) disable iff (rst)
      (ready && alias_rd_q) |-> (rdata[DATA_W-1:1] == '0));

   assert_outside_rd_zero_R9: assert property (@(posedge clk) disable iff (rst)
      (ready && none_rd_q) |-> (rdata == '0));

   assert_one_bit_change_R6: assert property (@(posedge clk) disable iff (rst)
      (st_q == SQ_STORE) |-> ($countones(rf_wr_data ^ hold_q) <= 1));

   assert_fetch_then_store_R8: assert property (@(posedge clk) disable iff (rst)
      (st_q == SQ_FETCH) |=> (st_q == SQ_STORE));

   assert_store_then_done_R8: assert property (@(posedge clk) disable iff (rst)
      (st_q == SQ_STORE) |=> (ready && !rf_wr_en));

endmodule

// File: rtl/bitalias_xlate.sv
module bitalias_xlate
   import bitalias_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned WORDS      = 8,
   parameter int unsigned TGT_BASE   = 0,
   parameter int unsigned ALIAS_BASE = 1024,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ready
);

   localparam int unsigned WIDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int unsigned BIT_W     = $clog2(DATA_W);
   localparam longint unsigned ALIAS_SPAN = longint'(WORDS) * DATA_W;
   localparam longint unsigned ADDR_SPACE = 64'd1 << ADDR_W;

   // Elaboration-time parameter checks
   if ((DATA_W < 2) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_bad_dw
      $error("DATA_W must be a power of two of at least 2");
   end
   if (WORDS < 1) begin : g_bad_words
      $error("WORDS must be at least 1");
   end
   if ((TGT_BASE + WORDS > ADDR_SPACE) || (ALIAS_BASE + ALIAS_SPAN > ADDR_SPACE)) begin : g_bad_fit
      $error("regions do not fit in the address space");
   end
   if (!((ALIAS_BASE >= TGT_BASE + WORDS) || (TGT_BASE >= ALIAS_BASE + ALIAS_SPAN))) begin : g_bad_overlap
      $error("target and alias regions overlap");
   end

   region_e           region;
   logic [WIDX_W-1:0] word_idx;
   logic [BIT_W-1:0]  bit_idx;
   logic [WIDX_W-1:0] rf_rd_idx;
   logic [DATA_W-1:0] rf_rd_data;
   logic              rf_wr_en;
   logic [WIDX_W-1:0] rf_wr_idx;
   logic [DATA_W-1:0] rf_wr_data;

   bitalias_decode #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .WORDS      (WORDS),
      .TGT_BASE   (TGT_BASE),
      .ALIAS_BASE (ALIAS_BASE)
   ) decode_i (
      .addr     (addr),
      .region   (region),
      .word_idx (word_idx),
      .bit_idx  (bit_idx)
   );

   bitalias_ctrl #(
      .DATA_W (DATA_W),
      .WORDS  (WORDS)
   ) ctrl_i (
      .clk        (clk),
      .rst        (rst),
      .req        (req),
      .we         (we),
      .wdata      (wdata),
      .region     (region),
      .word_in    (word_idx),
      .bit_in     (bit_idx),
      .rf_rd_idx  (rf_rd_idx),
      .rf_rd_data (rf_rd_data),
      .rf_wr_en   (rf_wr_en),
      .rf_wr_idx  (rf_wr_idx),
      .rf_wr_data (rf_wr_data),
      .rdata      (rdata),
      .ready      (ready)
   );

   bitalias_regfile #(
      .DATA_W    (DATA_W),
      .WORDS     (WORDS),
      .RESET_VAL (RESET_VAL)
   ) regfile_i (
      .clk     (clk),
      .rst     (rst),
      .rd_idx  (rf_rd_idx),
      .rd_data (rf_rd_data),
      .wr_en   (rf_wr_en),
      .wr_idx  (rf_wr_idx),
      .wr_data (rf_wr_data)
   );

   // Completion is never signalled while reset is held
   assert_quiet_in_reset_R1: assert property (@(posedge clk)
      rst |=> !ready);

endmodule

// File: tb/bitalias_xlate_tb.sv
`timescale 1ns/1ps
module bitalias_xlate_tb_top;

   localparam int ADDR_W = 12;
   localparam int DW     = 32;
   localparam int NW     = 8;
   localparam int TBASE  = 0;
   localparam int ABASE  = 1024;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              req = 1'b0;
   logic              we  = 1'b0;
   logic [ADDR_W-1:0] addr  = '0;
   logic [DW-1:0]     wdata = '0;
   logic [DW-1:0]     rdata;
   logic              ready;

   int n_chk  = 0;
   int n_fail = 0;
   logic [DW-1:0] model [NW];

   always #2.5 clk = ~clk;

   bitalias_xlate #(
      .ADDR_W(ADDR_W), .DATA_W(DW), .WORDS(NW),
      .TGT_BASE(TBASE), .ALIAS_BASE(ABASE)
   ) dut_i (
      .clk(clk), .rst(rst), .req(req), .we(we),
      .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready)
   );

   typedef struct packed {
      logic          wr;
      logic [11:0]   a;
      logic [31:0]   d;
      logic          cmp;
      logic [31:0]   exp;
      logic [7:0]    rq;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 12'h003, 32'hA5A5_0F0F, 1'b0, 32'h0,          8'd2},  // R2 direct write
      '{1'b0, 12'h003, 32'h0,         1'b1, 32'hA5A5_0F0F,  8'd2},  // R2 read back
      '{1'b0, 12'h460, 32'h0,         1'b1, 32'h0000_0001,  8'd4},  // R4 word3 bit0
      '{1'b0, 12'h464, 32'h0,         1'b1, 32'h0000_0000,  8'd5},  // R5 word3 bit4
      '{1'b1, 12'h464, 32'hFFFF_FFFF, 1'b0, 32'h0,          8'd6},  // R6 set word3 bit4
      '{1'b0, 12'h003, 32'h0,         1'b1, 32'hA5A5_0F1F,  8'd6},  // R6
      '{1'b1, 12'h47F, 32'hFFFF_FFFE, 1'b0, 32'h0,          8'd7},  // R7 clear word3 bit31
      '{1'b0, 12'h003, 32'h0,         1'b1, 32'h25A5_0F1F,  8'd7},  // R7
      '{1'b1, 12'h400, 32'h0000_0001, 1'b0, 32'h0,          8'd5},  // R5 word0 bit0
      '{1'b1, 12'h4FF, 32'h0000_0001, 1'b0, 32'h0,          8'd5},  // R5 word7 bit31
      '{1'b0, 12'h007, 32'h0,         1'b1, 32'h8000_0000,  8'd5},  // R5
      '{1'b0, 12'h000, 32'h0,         1'b1, 32'h0000_0001,  8'd5},  // R5
      '{1'b0, 12'h4FF, 32'h0,         1'b1, 32'h0000_0001,  8'd4},  // R4
      '{1'b1, 12'h200, 32'hDEAD_BEEF, 1'b0, 32'h0,          8'd9},  // R9 write outside
      '{1'b0, 12'h200, 32'h0,         1'b1, 32'h0000_0000,  8'd9},  // R9 read outside
      '{1'b0, 12'h004, 32'h0,         1'b1, 32'h0000_0000,  8'd9}   // R9 no side effect
   };

   task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   function automatic bit is_alias(input logic [ADDR_W-1:0] a);
      return (a >= ABASE) && (a < ABASE + NW*DW);
   endfunction

   // One bus access; checks latency (R3/R8) and the single-cycle ready (R10)
   task automatic access(input logic w, input logic [ADDR_W-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] rd);
      int cyc = 0;
      int exp_cyc;
      exp_cyc = (w && is_alias(a)) ? 3 : 1;
      @(negedge clk);
      req = 1'b1; we = w; addr = a; wdata = d;
      do begin
         @(negedge clk);
         cyc++;
      end while (!ready && cyc < 20);
      rd = rdata;
      if (exp_cyc == 3) chk("R8 latency", DW'(cyc), DW'(exp_cyc));
      else              chk("R3 latency", DW'(cyc), DW'(exp_cyc));
      @(posedge clk);
      #1;
      req = 1'b0;
      chk("R10 ready pulse", DW'(ready), '0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [DW-1:0] r;
      repeat (4) @(posedge clk);
      #1;
      chk("R1 ready in reset", DW'(ready), '0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 ready after reset", DW'(ready), '0);
      chk("R1 rdata after reset", rdata, '0);
      for (int i = 0; i < NW; i++) begin
         access(1'b0, ADDR_W'(TBASE + i), '0, r);
         chk("R1 word reset", r, '0);
         model[i] = '0;
      end

      // Vector table walk
      for (int v = 0; v < NV; v++) begin
         access(VECS[v].wr, VECS[v].a, VECS[v].d, r);
         if (VECS[v].cmp) chk($sformatf("R%0d vector %0d", VECS[v].rq, v), r, VECS[v].exp);
      end

      // Re-sync model with what the table left behind
      model[0] = 32'h0000_0001; model[3] = 32'h25A5_0F1F; model[7] = 32'h8000_0000;

      // Random mix against a bit-array model (R2 R4 R5 R6 R7 R9)
      for (int k = 0; k < 400; k++) begin
         int op = int'($urandom % 5);
         int w  = int'($urandom % NW);
         int b  = int'($urandom % DW);
         logic [DW-1:0] d = $urandom;
         case (op)
            0: begin
               access(1'b1, ADDR_W'(TBASE + w), d, r);
               model[w] = d;
            end
            1: begin
               access(1'b0, ADDR_W'(TBASE + w), '0, r);
               chk("R2 random direct read", r, model[w]);
            end
            2: begin
               access(1'b0, ADDR_W'(ABASE + w*DW + b), '0, r);
               chk("R4 random alias read", r, DW'(model[w][b]));
            end
            3: begin
               access(1'b1, ADDR_W'(ABASE + w*DW + b), d, r);
               model[w][b] = d[0];
            end
            default: begin
               access(1'b1, ADDR_W'(16 + (k % 900)), d, r);
               access(1'b0, ADDR_W'(TBASE + w), '0, r);
               chk("R9 random outside write", r, model[w]);
            end
         endcase
      end

      // Final sweep of every word
      for (int i = 0; i < NW; i++) begin
         access(1'b0, ADDR_W'(TBASE + i), '0, r);
         chk("R6 final word", r, model[i]);
      end

      // Reset mid-run clears all words again
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      access(1'b0, ADDR_W'(TBASE + 3), '0, r);
      chk("R1 word after second reset", r, '0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule